// File: doc/BRIEF.md
# Voltage/Frequency Domain Control Registers

This block is a word-addressed register file through which software finds the voltage/frequency domains of a chip, reads each domain's table of operating points, and asks for a new performance level. Discovery works indirectly. Software writes a list index, and the block loads the matching domain identifier into the selected-domain register. A level number written to a selector then chooses which table row the frequency and voltage registers return for that domain.

A write to the performance-level register latches the level for the selected domain. The level is clamped to the last valid entry if it is too high. The write emits a one-cycle request carrying the domain identifier and level toward a regulator and clock stub, and starts a countdown of the programmed transition latency. When the countdown ends, an acknowledge flag goes to 1. The flag drops back to 0 when software reads it as 1, so a polling loop sees each completion exactly once.

The generated tables follow fixed formulas:
- Domain slot d has identifier 1 + 2·d.
- Even slots have 4 levels and odd slots have 3.
- Frequency is 1 000 000 + 100 000·d − 200 000·l kHz.
- Voltage is 1 000 000 + 50 000·d − 100 000·l µV.
- Level 0 is the fastest level.

Top module: `dvfs_regif`

## Requirements
- R1: After reset, the registers read as follows: status = 1 (when enabled), domain count = 3, list index = 0, domain ID = 1, latency = 8, performance level = 0, ack = 0.
- R2: Writing a list index below the domain count stores it and loads the domain ID register with that entry's identifier. An index at or above the count changes nothing.
- R3: Writing a configured identifier to the domain ID register selects that domain. Any other value leaves the selection unchanged.
- R4: The level-count register and the frequency (kHz) and voltage (µV) registers report the selected domain's table at the level written to the level selector. A selector at or beyond the level count reads 0 from both.
- R5: A performance-level write stores the level for the selected domain only. A value at or above that domain's level count is stored as count − 1. Reading the performance-level register returns the selected domain's stored level.
- R6: In the cycle after a performance-level write, `req_valid_o` is 1 for exactly one cycle, with the domain identifier on `req_dom_id_o` and the stored level on `req_level_o`.
- R7: A performance-level write clears the ack. With latency L, the ack reads 1 from the (L+1)th clock edge after the write edge onward. A new write restarts the count.
- R8: A read of the ack register that returns 1 clears it to 0. A read that returns 0 changes nothing.
- R9: The transition latency register is read/write, with a 16-bit value in clock cycles.
- R10: Registers sit at byte offset 4×index, in this order: status, domain count, list index, latency, domain ID, performance level, ack, level count, level selector, frequency, voltage. Unaligned or unused offsets read 0. Writes to status, domain count, ack, level count, frequency and voltage are ignored.
- R11: With DVFS disabled, status reads 0 and performance-level writes change no level, emit no request and leave the ack at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| req_valid_o | output | 1 | One-cycle level-change request |
| req_dom_id_o | output | 8 | Identifier of the domain being changed |
| req_level_o | output | 2 | Requested (clamped) level |

## Verification
Two events can land on the same clock edge. The first is the latency countdown expiring. The second is a software read of the ack register that would clear it. The bench sets the latency to 3, writes a level, waits three idle cycles, and reads the ack in the cycle whose edge ends the count. That read must return 0, and the following read must return 1, which proves the completion was neither lost nor cleared early; a third read must return 0 again. A second case restarts a pending countdown with a new write, and checks that the ack stays low until the full new window has passed. A cycle-accurate model in the bench also checks the request outputs on every cycle.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    // Word index of each register (byte offset = 4 * index)
    localparam int unsigned RI_STATUS = 0;
    localparam int unsigned RI_NDOM   = 1;
    localparam int unsigned RI_DIDX   = 2;
    localparam int unsigned RI_LAT    = 3;
    localparam int unsigned RI_DOMID  = 4;
    localparam int unsigned RI_PERF   = 5;
    localparam int unsigned RI_ACK    = 6;
    localparam int unsigned RI_NLVL   = 7;
    localparam int unsigned RI_LSEL   = 8;
    localparam int unsigned RI_FREQ   = 9;
    localparam int unsigned RI_VOLT   = 10;
    localparam int unsigned NUM_REGS  = 11;

    // Odd domain slots expose one level fewer than the maximum
    function automatic int unsigned lvl_count(int unsigned slot, int unsigned max_lv);
        if ((slot % 2) == 1 && max_lv > 1)
            return max_lv - 1;
        return max_lv;
    endfunction

endpackage

// File: rtl/dvfs_level_table.sv
module dvfs_level_table #(
    parameter int NUM_DOM       = 3,
    parameter int MAX_LV        = 4,
    parameter int DOM_W         = 2,
    parameter int FREQ_BASE_KHZ = 1000000,
    parameter int FREQ_DOM_KHZ  = 100000,
    parameter int FREQ_LVL_KHZ  = 200000,
    parameter int VOLT_BASE_UV  = 1000000,
    parameter int VOLT_DOM_UV   = 50000,
    parameter int VOLT_LVL_UV   = 100000
) (
    input  logic [DOM_W-1:0] slot_i,
    input  logic [31:0]      lsel_i,
    output logic [31:0]      nlev_o,
    output logic [31:0]      freq_o,
    output logic [31:0]      volt_o
);
    import dvfs_pkg::*;

    logic [31:0] nlev_tab [NUM_DOM];
    logic [31:0] freq_tab [NUM_DOM][MAX_LV];
    logic [31:0] volt_tab [NUM_DOM][MAX_LV];

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign nlev_tab[d] = 32'(lvl_count(d, MAX_LV));
        for (genvar l = 0; l < MAX_LV; l++) begin : g_lvl
            assign freq_tab[d][l] = 32'(FREQ_BASE_KHZ + d * FREQ_DOM_KHZ - l * FREQ_LVL_KHZ);
            assign volt_tab[d][l] = 32'(VOLT_BASE_UV + d * VOLT_DOM_UV - l * VOLT_LVL_UV);
        end
    end

    always_comb begin
        nlev_o = '0;
        freq_o = '0;
        volt_o = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (DOM_W'(d) == slot_i) begin
                nlev_o = nlev_tab[d];
                for (int l = 0; l < MAX_LV; l++) begin
                    if (32'(l) == lsel_i && lsel_i < nlev_tab[d]) begin
                        freq_o = freq_tab[d][l];
                        volt_o = volt_tab[d][l];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dvfs_ack_timer.sv
module dvfs_ack_timer #(
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LAT_W-1:0] lat_i,
    input  logic             clr_i,
    output logic             ack_o
);
    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
        logic             ack;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i && st_q.ack)
            st_d.ack = 1'b0;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.cnt  = lat_i;
            st_d.ack  = 1'b0;
        end else if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.ack  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack_o = st_q.ack;

    // R7
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !ack_o);

    // R7
    ack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0 && !start_i) |=> (!ack_o && st_q.busy));

    // R7
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(st_q.busy));

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ack_o && !start_i) |=> !ack_o);

endmodule

// File: rtl/dvfs_regif.sv
module dvfs_regif #(
    parameter int NUM_DOM       = 3,
    parameter int MAX_LV        = 4,
    parameter int ID_BASE       = 1,
    parameter int ID_STEP       = 2,
    parameter int ID_W          = 8,
    parameter bit DVFS_EN       = 1'b1,
    parameter int LAT_W         = 16,
    parameter int LAT_RESET     = 8,
    parameter int ADDR_W        = 6,
    parameter int FREQ_BASE_KHZ = 1000000,
    parameter int FREQ_DOM_KHZ  = 100000,
    parameter int FREQ_LVL_KHZ  = 200000,
    parameter int VOLT_BASE_UV  = 1000000,
    parameter int VOLT_DOM_UV   = 50000,
    parameter int VOLT_LVL_UV   = 100000,
    localparam int DOM_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    localparam int LVL_W = (MAX_LV > 1) ? $clog2(MAX_LV) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              req_valid_o,
    output logic [ID_W-1:0]   req_dom_id_o,
    output logic [LVL_W-1:0]  req_level_o
);
    import dvfs_pkg::*;

    localparam int WIDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [DOM_W-1:0]              didx;
        logic [DOM_W-1:0]              slot;
        logic [LAT_W-1:0]              lat;
        logic [31:0]                   lsel;
        logic [NUM_DOM-1:0][LVL_W-1:0] perf;
        logic                          req;
        logic [ID_W-1:0]               req_id;
        logic [LVL_W-1:0]              req_lvl;
    } regs_t;

    regs_t st_d, st_q;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              wr_en;
    logic              rd_en;
    logic [31:0]       nlev;
    logic [31:0]       freq;
    logic [31:0]       volt;
    logic              ack;
    logic              id_hit;
    logic [DOM_W-1:0]  id_slot;
    logic [ID_W-1:0]   cur_id;
    logic [31:0]       lvl_clamp;
    logic              tmr_start;
    logic              tmr_clr;

    assign widx    = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign wr_en   = bus_sel_i && bus_wr_i && aligned;
    assign rd_en   = bus_sel_i && !bus_wr_i && aligned;
    assign cur_id  = ID_W'(32'(ID_BASE) + 32'(st_q.slot) * 32'(ID_STEP));

    dvfs_level_table #(
        .NUM_DOM      (NUM_DOM),
        .MAX_LV       (MAX_LV),
        .DOM_W        (DOM_W),
        .FREQ_BASE_KHZ(FREQ_BASE_KHZ),
        .FREQ_DOM_KHZ (FREQ_DOM_KHZ),
        .FREQ_LVL_KHZ (FREQ_LVL_KHZ),
        .VOLT_BASE_UV (VOLT_BASE_UV),
        .VOLT_DOM_UV  (VOLT_DOM_UV),
        .VOLT_LVL_UV  (VOLT_LVL_UV)
    ) u_table (
        .slot_i(st_q.slot),
        .lsel_i(st_q.lsel),
        .nlev_o(nlev),
        .freq_o(freq),
        .volt_o(volt)
    );

    assign tmr_start = DVFS_EN && wr_en && (32'(widx) == RI_PERF);
    assign tmr_clr   = rd_en && (32'(widx) == RI_ACK);

    dvfs_ack_timer #(.LAT_W(LAT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(tmr_start),
        .lat_i  (st_q.lat),
        .clr_i  (tmr_clr),
        .ack_o  (ack)
    );

    // Identifier lookup and level clamp
    always_comb begin
        id_hit  = 1'b0;
        id_slot = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (bus_wdata_i == 32'(ID_BASE + d * ID_STEP)) begin
                id_hit  = 1'b1;
                id_slot = DOM_W'(d);
            end
        end
        if (bus_wdata_i >= nlev) lvl_clamp = nlev - 32'd1;
        else                     lvl_clamp = bus_wdata_i;
    end

    // Next-state
    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (wr_en) begin
            case (32'(widx))
                RI_DIDX: begin
                    if (bus_wdata_i < 32'(NUM_DOM)) begin
                        st_d.didx = bus_wdata_i[DOM_W-1:0];
                        st_d.slot = bus_wdata_i[DOM_W-1:0];
                    end
                end
                RI_LAT:   st_d.lat = bus_wdata_i[LAT_W-1:0];
                RI_DOMID: if (id_hit) st_d.slot = id_slot;
                RI_PERF: begin
                    if (DVFS_EN) begin
                        st_d.perf[st_q.slot] = lvl_clamp[LVL_W-1:0];
                        st_d.req             = 1'b1;
                        st_d.req_id          = cur_id;
                        st_d.req_lvl         = lvl_clamp[LVL_W-1:0];
                    end
                end
                RI_LSEL:  st_d.lsel = bus_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.lat <= LAT_W'(LAT_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        if (rd_en) begin
            case (32'(widx))
                RI_STATUS: bus_rdata_o = 32'(DVFS_EN);
                RI_NDOM:   bus_rdata_o = 32'(NUM_DOM);
                RI_DIDX:   bus_rdata_o = 32'(st_q.didx);
                RI_LAT:    bus_rdata_o = 32'(st_q.lat);
                RI_DOMID:  bus_rdata_o = 32'(cur_id);
                RI_PERF:   bus_rdata_o = 32'(st_q.perf[st_q.slot]);
                RI_ACK:    bus_rdata_o = {31'd0, ack};
                RI_NLVL:   bus_rdata_o = nlev;
                RI_LSEL:   bus_rdata_o = st_q.lsel;
                RI_FREQ:   bus_rdata_o = freq;
                RI_VOLT:   bus_rdata_o = volt;
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    assign req_valid_o  = st_q.req;
    assign req_dom_id_o = st_q.req_id;
    assign req_level_o  = st_q.req_lvl;

    // R6
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> $past(bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(RI_PERF * 4))));

    // R3
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && bus_wr_i) |=> $stable(st_q.slot));

    // R5
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.perf[st_q.slot]) < nlev);

    if (!DVFS_EN) begin : g_off
        // R11
        off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid_o && !ack);
    end

endmodule

// File: tb/dvfs_regif_test.sv
`timescale 1ns/1ps
module dvfs_regif_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, off_rdata;
    logic        req_v, off_req_v;
    logic [7:0]  req_id, off_req_id;
    logic [1:0]  req_lv, off_req_lv;

    always #2 clk = ~clk;

    dvfs_regif uut (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .req_valid_o(req_v), .req_dom_id_o(req_id), .req_level_o(req_lv)
    );

    dvfs_regif #(.DVFS_EN(1'b0)) uut_off (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(off_rdata),
        .req_valid_o(off_req_v), .req_dom_id_o(off_req_id), .req_level_o(off_req_lv)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model
    int          m_didx, m_slot, m_lat, m_perf[3], m_rem, m_req_id, m_req_lvl;
    int unsigned m_lsel;
    bit          m_ack, m_req;

    function automatic int nl(int d);       return (d % 2) ? 3 : 4; endfunction
    function automatic int idof(int d);     return 1 + 2 * d; endfunction
    function automatic int fq(int d, int l); return 1000000 + 100000 * d - 200000 * l; endfunction
    function automatic int vt(int d, int l); return 1000000 + 50000 * d - 100000 * l; endfunction

    function automatic int exp_rd(int a);
        if (a % 4 != 0) return 0;
        case (a / 4)
            0: return 1;
            1: return 3;
            2: return m_didx;
            3: return m_lat;
            4: return idof(m_slot);
            5: return m_perf[m_slot];
            6: return int'(m_ack);
            7: return nl(m_slot);
            8: return int'(m_lsel);
            9: return (m_lsel < nl(m_slot)) ? fq(m_slot, int'(m_lsel)) : 0;
            10: return (m_lsel < nl(m_slot)) ? vt(m_slot, int'(m_lsel)) : 0;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_didx = 0; m_slot = 0; m_lat = 8; m_lsel = 0; m_ack = 0; m_rem = 0;
            m_req = 0; m_req_id = 0; m_req_lvl = 0;
            foreach (m_perf[i]) m_perf[i] = 0;
        end else begin
            bit perf_wr;
            int unsigned wd;
            wd = wdata;
            perf_wr = sel && wr && addr == 6'd20;
            m_req = 0;
            if (sel && !wr && addr == 6'd24 && m_ack) m_ack = 0;
            if (perf_wr) begin
                int lv;
                lv = (wd >= nl(m_slot)) ? nl(m_slot) - 1 : int'(wd);
                m_perf[m_slot] = lv;
                m_req = 1; m_req_id = idof(m_slot); m_req_lvl = lv;
                m_ack = 0; m_rem = m_lat + 1;
            end else if (m_rem > 0) begin
                m_rem--;
                if (m_rem == 0) m_ack = 1;
            end
            if (sel && wr) begin
                case (addr)
                    6'd8:  if (wd < 3) begin m_didx = int'(wd); m_slot = int'(wd); end
                    6'd12: m_lat = int'(wd & 32'hFFFF);
                    6'd16: for (int d = 0; d < 3; d++) if (wd == idof(d)) m_slot = d;
                    6'd32: m_lsel = wd;
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison of the request outputs
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 req_valid", req_v, m_req);
            if (m_req) begin
                check("R6 req_dom_id", req_id, m_req_id);
                check("R6 req_level", req_lv, m_req_lvl);
            end
            check("R11 disabled req_valid", off_req_v, 0);
        end
    end

    task automatic bwr(int a, int unsigned d);
        @(negedge clk);
        sel = 1; wr = 1; addr = 6'(a); wdata = d;
        @(posedge clk);
    endtask

    task automatic brd(int a, string tag);
        @(negedge clk);
        sel = 1; wr = 0; addr = 6'(a); wdata = 0;
        #1 check(tag, rdata, exp_rd(a));
        @(posedge clk);
    endtask

    task automatic brdx(int a, int exp, string tag);
        @(negedge clk);
        sel = 1; wr = 0; addr = 6'(a); wdata = 0;
        #1 check(tag, rdata, exp);
        @(posedge clk);
    endtask

    task automatic brd_off(int a, int exp, string tag);
        @(negedge clk);
        sel = 1; wr = 0; addr = 6'(a); wdata = 0;
        #1 check(tag, off_rdata, exp);
        @(posedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            sel = 0; wr = 0;
            @(posedge clk);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog (R7): actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1 reset state
        brdx(0, 1, "R1 status");
        brdx(4, 3, "R1 domain count");
        brdx(8, 0, "R1 list index");
        brdx(12, 8, "R1 latency");
        brdx(16, 1, "R1 domain id");
        brdx(20, 0, "R1 perf level");
        brdx(24, 0, "R1 ack");

        // R10 unused / unaligned offsets and read-only writes
        brdx(44, 0, "R10 unused offset");
        brdx(5, 0, "R10 unaligned");
        bwr(0, 7); bwr(4, 9); bwr(28, 9); bwr(36, 5); bwr(24, 1);
        brdx(0, 1, "R10 status after write");
        brdx(4, 3, "R10 count after write");
        brdx(28, 4, "R10 nlev after write");
        brdx(36, 1000000, "R10 freq after write");
        brdx(24, 0, "R10 ack after write");

        // R2 indexed discovery
        bwr(8, 2);
        brdx(16, 5, "R2 id at index 2");
        brdx(8, 2, "R2 index readback");
        bwr(8, 3);
        brdx(16, 5, "R2 out-of-range index");
        brdx(8, 2, "R2 index kept");

        // R3 domain select
        bwr(16, 3);
        brdx(16, 3, "R3 select id 3");
        bwr(16, 4);
        brdx(16, 3, "R3 unknown id 4 ignored");
        bwr(16, 0);
        brdx(16, 3, "R3 unknown id 0 ignored");

        // R4 table sweep
        for (int d = 0; d < 3; d++) begin
            bwr(16, idof(d));
            brd(28, "R4 level count");
            for (int l = 0; l < 5; l++) begin
                bwr(32, l);
                brd(32, "R4 selector");
                brd(36, "R4 frequency");
                brd(40, "R4 voltage");
            end
        end
        bwr(16, 3); bwr(32, 2);
        brdx(36, 700000, "R4 freq dom id 3 lvl 2");
        brdx(40, 850000, "R4 volt dom id 3 lvl 2");
        bwr(32, 3);
        brdx(36, 0, "R4 freq beyond table");
        brdx(40, 0, "R4 volt beyond table");

        // R9 latency register
        bwr(12, 3);
        brdx(12, 3, "R9 latency readback");

        // R7/R8 expiry collides with ack read
        bwr(20, 1);
        idle(3);
        brdx(24, 0, "R7 read on expiry edge");
        brdx(24, 1, "R8 ack visible");
        brdx(24, 0, "R8 ack cleared by read");
        brdx(24, 0, "R8 zero read keeps zero");
        brdx(20, 1, "R5 level stored");

        // R5 clamp and per-domain storage
        bwr(20, 9);
        brdx(20, 2, "R5 clamp odd domain");
        idle(5);
        brd(24, "R7 ack after clamp write");
        bwr(16, 1);
        brdx(20, 0, "R5 other domain untouched");
        bwr(20, 5);
        brdx(20, 3, "R5 clamp even domain");
        bwr(16, 3);
        brdx(20, 2, "R5 odd domain kept");

        // R7 restart while pending
        bwr(12, 10);
        bwr(20, 0);
        idle(4);
        bwr(20, 1);
        idle(10);
        brdx(24, 0, "R7 restart still pending");
        brdx(24, 1, "R7 restart done");

        // R7 zero latency
        bwr(12, 0);
        bwr(20, 2);
        brdx(24, 0, "R7 zero latency first edge");
        brdx(24, 1, "R7 zero latency done");
        brd(24, "R8 cleared");

        // R11 disabled instance
        bwr(20, 1);
        brd_off(0, 0, "R11 status disabled");
        brd_off(20, 0, "R11 level unchanged");
        idle(3);
        brd_off(24, 0, "R11 ack stays 0");
        brd(24, "R7 enabled ack");

        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule